// File: doc/BRIEF.md
# Crosspoint Routing Configuration Register

This block holds the routing program for a switch matrix with 16 sources and 8 destinations. For every destination it drives a 4-bit source number and an enable bit. When the enable bit is 0 the destination is disabled and carries no source, whatever its source number holds. The matrix itself is outside the block.

Programming uses two register ranks. The first is a 40-bit shift word. It can be filled serially, one bit per falling edge of the programming clock. It can also be patched one destination at a time through a parallel port with an address and a 5-bit field. The second rank drives the matrix. It takes the first rank's content whenever the update strobe and the chip enable are both low. Because it loads the first rank's *next* value, an update applied in the same cycle as the final shift or a parallel write passes that cycle's data through. The last bit of the shift word leaves on a serial output, so devices can be chained. A low reset disables every destination and leaves all source numbers untouched.

Top module: `xbar_route_cfg`

## Requirements
- R1: All activity happens on the falling edge of `pclk`. With `par_mode`=0 and `ce_n`=0, each edge shifts the word left by one (word = {word[38:0], sdi}). Destination k occupies word bits [5k+4:5k]: bit 5k+4 is its enable and bits 5k+3..5k are its source. The first of 40 bits shifted therefore becomes destination 7's enable, and the last becomes destination 0's source LSB.
- R2: While `ce_n`=0 and `upd_n`=0 in serial mode, the routing outputs after each edge equal the shift word, including the bit shifted on that edge.
- R3: While `upd_n`=1, the routing outputs do not change, even while serial or parallel loading proceeds.
- R4: While `ce_n`=1, nothing changes: routing outputs, shift word and `sdo` all hold, whatever the other inputs do.
- R5: `sdo` presents bit 39 of the shift word, so after each serial edge it shows the bit that was at position 38 before that edge.
- R6: With `par_mode`=1, `ce_n`=0 and `upd_n`=0, one edge writes `wr_data` (bit 4 enable, bits 3..0 source) to destination `wr_addr` in both ranks. Every other destination keeps its routing.
- R7: A parallel write with `upd_n`=1 changes only the shift word. The written field can later be observed by shifting it out on `sdo`.
- R8: An edge with `rst_n`=0 clears every enable bit in both ranks and does nothing else. Source numbers in both ranks are kept, and reset overrides any shift or write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Programming clock; the block acts on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset that clears enables only |
| ce_n | input | 1 | Active-low chip enable; gates every load |
| upd_n | input | 1 | Active-low update strobe; opens the routing rank |
| par_mode | input | 1 | 0 selects serial loading, 1 selects parallel loading |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (last bit of the shift word) |
| wr_addr | input | 3 | Destination addressed by a parallel write |
| wr_data | input | 5 | Parallel field: bit 4 enable, bits 3..0 source |
| route_sel | output | 32 | Source number of destination k on bits [4k+3:4k] |
| route_en | output | 8 | Enable of destination k on bit k |

## Verification
Two functions can land on the same edge. The first is the update strobe together with the last serial shift or a parallel write: the routing rank must show the data loaded on that edge, not the word from before it. The bench provokes this by lowering `upd_n` only on the 40th bit of each serial load and on every parallel write. The second is reset together with a parallel write. Here reset must win: only the enables clear, and the written field must not appear. The bench judges this at the routing ports, and by shifting the first rank out on `sdo` after reset to confirm its source numbers survived with enables cleared.

// File: rtl/xbar_cfg_pkg.sv
// Package: shared defaults and mode encoding for the crosspoint
// routing configuration register.
// Assumes: sources and destinations are powers of two in normal use.
package xbar_cfg_pkg;
    localparam int unsigned DEF_SOURCES = 16;
    localparam int unsigned DEF_DESTS   = 8;

    // Loading mode selected by the par_mode pin.
    typedef enum logic {
        LOAD_SERIAL   = 1'b0,
        LOAD_PARALLEL = 1'b1
    } load_mode_e;

    // Number of bits of one destination field: source number plus enable.
    function automatic int unsigned field_bits(input int unsigned sources);
        return $clog2(sources) + 1;
    endfunction
endpackage

// File: rtl/xbar_shift_rank.sv
// Module: first register rank (shift word).
// Shifts serial data in MSB-first, or overwrites one destination field
// from the parallel port. Reset clears only the enable bit of each field.
// Exposes its next-state value so the routing rank can load it on the
// same edge. Assumes the caller never asserts shift_en and wr_en together.
module xbar_shift_rank #(
    parameter int unsigned N_DEST  = 8,
    parameter int unsigned FIELD_W = 5,
    parameter int unsigned ADDR_W  = 3,
    localparam int unsigned WORD_W = N_DEST * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdi,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [WORD_W-1:0] word_q,
    output logic [WORD_W-1:0] word_nxt
);
    // Next value: reset clears enables, else shift, else parallel patch.
    always_comb begin
        word_nxt = word_q;
        if (!rst_n) begin
            for (int k = 0; k < int'(N_DEST); k++) begin
                word_nxt[k*FIELD_W + FIELD_W - 1] = 1'b0;
            end
        end else if (shift_en) begin
            word_nxt = {word_q[WORD_W-2:0], sdi};
        end else if (wr_en && (int'(wr_addr) < int'(N_DEST))) begin
            word_nxt[int'(wr_addr)*FIELD_W +: FIELD_W] = wr_data;
        end
    end

    // Register the shift word on the falling programming-clock edge.
    always_ff @(negedge clk) begin
        word_q <= word_nxt;
    end
endmodule

// File: rtl/xbar_route_rank.sv
// Module: second register rank (routing word driving the matrix).
// Loads the whole word (serial mode) or one addressed field (parallel
// mode) from the first rank's next value, which models a transparent
// latch as a register refreshed every edge the strobe is open.
// Reset clears enables only. Assumes load_all and load_one are exclusive.
module xbar_route_rank #(
    parameter int unsigned N_DEST  = 8,
    parameter int unsigned FIELD_W = 5,
    parameter int unsigned ADDR_W  = 3,
    localparam int unsigned WORD_W = N_DEST * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_all,
    input  logic               load_one,
    input  logic [ADDR_W-1:0]  sel_addr,
    input  logic [WORD_W-1:0]  src_word,
    output logic [WORD_W-1:0]  route_q
);
    logic [WORD_W-1:0] route_nxt;

    // Next value: reset clears enables, else full or single-field load.
    always_comb begin
        route_nxt = route_q;
        if (!rst_n) begin
            for (int k = 0; k < int'(N_DEST); k++) begin
                route_nxt[k*FIELD_W + FIELD_W - 1] = 1'b0;
            end
        end else if (load_all) begin
            route_nxt = src_word;
        end else if (load_one && (int'(sel_addr) < int'(N_DEST))) begin
            route_nxt[int'(sel_addr)*FIELD_W +: FIELD_W] =
                src_word[int'(sel_addr)*FIELD_W +: FIELD_W];
        end
    end

    // Register the routing word on the falling programming-clock edge.
    always_ff @(negedge clk) begin
        route_q <= route_nxt;
    end
endmodule

// File: rtl/xbar_route_cfg.sv
// Module: crosspoint routing configuration register (top).
// Decodes chip enable, mode and update strobe into rank controls,
// chains the serial output from the shift word's top bit and unpacks
// the routing word into per-destination source numbers and enables.
// Assumes all inputs are stable around the falling edge of pclk.
module xbar_route_cfg
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned N_SRC  = DEF_SOURCES,
    parameter int unsigned N_DEST = DEF_DESTS,
    localparam int unsigned SEL_W   = $clog2(N_SRC),
    localparam int unsigned FIELD_W = SEL_W + 1,
    localparam int unsigned ADDR_W  = $clog2(N_DEST),
    localparam int unsigned WORD_W  = N_DEST * FIELD_W
) (
    input  logic                      pclk,
    input  logic                      rst_n,
    input  logic                      ce_n,
    input  logic                      upd_n,
    input  logic                      par_mode,
    input  logic                      sdi,
    output logic                      sdo,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [FIELD_W-1:0]        wr_data,
    output logic [N_DEST*SEL_W-1:0]   route_sel,
    output logic [N_DEST-1:0]         route_en
);
    load_mode_e        mode;
    logic              selected;
    logic              strobe_open;
    logic              shift_en;
    logic              wr_en;
    logic              load_all;
    logic              load_one;
    logic [WORD_W-1:0] shift_word;
    logic [WORD_W-1:0] shift_next;
    logic [WORD_W-1:0] route_word;

    // Decode the pins into per-rank load controls.
    always_comb begin
        mode        = load_mode_e'(par_mode);
        selected    = !ce_n;
        strobe_open = selected && !upd_n;
        shift_en    = selected && (mode == LOAD_SERIAL);
        wr_en       = selected && (mode == LOAD_PARALLEL);
        load_all    = strobe_open && (mode == LOAD_SERIAL);
        load_one    = strobe_open && (mode == LOAD_PARALLEL);
    end

    xbar_shift_rank #(
        .N_DEST (N_DEST),
        .FIELD_W(FIELD_W),
        .ADDR_W (ADDR_W)
    ) u_shift (
        .clk     (pclk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .sdi     (sdi),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .word_q  (shift_word),
        .word_nxt(shift_next)
    );

    xbar_route_rank #(
        .N_DEST (N_DEST),
        .FIELD_W(FIELD_W),
        .ADDR_W (ADDR_W)
    ) u_route (
        .clk     (pclk),
        .rst_n   (rst_n),
        .load_all(load_all),
        .load_one(load_one),
        .sel_addr(wr_addr),
        .src_word(shift_next),
        .route_q (route_word)
    );

    // Serial chain output is the top bit of the shift word.
    assign sdo = shift_word[WORD_W-1];

    // Unpack each destination field into source number and enable.
    for (genvar k = 0; k < int'(N_DEST); k++) begin : g_unpack
        assign route_sel[k*SEL_W +: SEL_W] = route_word[k*FIELD_W +: SEL_W];
        assign route_en[k]                 = route_word[k*FIELD_W + SEL_W];
    end
endmodule

// File: rtl/xbar_route_cfg_chk.sv
// Module: property checker bound to xbar_route_cfg.
// Rebuilds the routing word from the output pins and relates it to the
// shift word and the control pins over successive falling edges.
module xbar_route_cfg_chk #(
    parameter int unsigned N_DEST = 8,
    parameter int unsigned SEL_W  = 4,
    localparam int unsigned FW     = SEL_W + 1,
    localparam int unsigned ADDR_W = $clog2(N_DEST),
    localparam int unsigned WW     = N_DEST * FW
) (
    input logic                    pclk,
    input logic                    rst_n,
    input logic                    ce_n,
    input logic                    upd_n,
    input logic                    par_mode,
    input logic                    sdi,
    input logic                    sdo,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [FW-1:0]           wr_data,
    input logic [N_DEST*SEL_W-1:0] route_sel,
    input logic [N_DEST-1:0]       route_en,
    input logic [WW-1:0]           shift_q
);
    logic [WW-1:0]     rt_word;
    logic [ADDR_W-1:0] addr_q;
    logic [FW-1:0]     rt_pick;

    for (genvar k = 0; k < int'(N_DEST); k++) begin : g_pack
        assign rt_word[k*FW +: FW] = {route_en[k], route_sel[k*SEL_W +: SEL_W]};
    end

    // Remember the previous edge's address to pick the written field.
    always_ff @(negedge pclk) begin
        addr_q <= wr_addr;
    end
    assign rt_pick = rt_word[int'(addr_q)*FW +: FW];

    // R2
    transparent_follow_chk: assert property (@(negedge pclk) disable iff (!rst_n)
        (!ce_n && !upd_n && !par_mode) |=> rt_word == {$past(shift_q[WW-2:0]), $past(sdi)});

    // R3
    route_hold_chk: assert property (@(negedge pclk) disable iff (!rst_n)
        (!ce_n && upd_n) |=> $stable(rt_word));

    // R4
    idle_hold_chk: assert property (@(negedge pclk) disable iff (!rst_n)
        ce_n |=> ($stable(rt_word) && $stable(sdo) && $stable(shift_q)));

    // R5
    chain_out_chk: assert property (@(negedge pclk) disable iff (!rst_n)
        (!ce_n && !par_mode) |=> sdo == $past(shift_q[WW-2]));

    // R6
    field_write_chk: assert property (@(negedge pclk) disable iff (!rst_n)
        (!ce_n && !upd_n && par_mode && (int'(wr_addr) < int'(N_DEST)))
            |=> rt_pick == $past(wr_data));

    // R8
    reset_disable_chk: assert property (@(negedge pclk)
        !rst_n |=> route_en == '0);
endmodule

bind xbar_route_cfg xbar_route_cfg_chk #(
    .N_DEST(N_DEST),
    .SEL_W (SEL_W)
) u_chk (
    .pclk     (pclk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .upd_n    (upd_n),
    .par_mode (par_mode),
    .sdi      (sdi),
    .sdo      (sdo),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .route_sel(route_sel),
    .route_en (route_en),
    .shift_q  (shift_word)
);

// File: tb/xbar_route_cfg_test.sv
// Bench: sweeps serial loads, transparent shifting, every parallel
// address/field pair, idle cycles and reset collisions, comparing the
// output pins with a word model derived from the requirements.
module xbar_route_cfg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, ce_n = 1'b1, upd_n = 1'b1, par_mode = 1'b0, sdi = 1'b0;
    logic       sdo;
    logic [2:0] wr_addr = '0;
    logic [4:0] wr_data = '0;
    logic [31:0] route_sel;
    logic [7:0]  route_en;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [39:0] exp_sr = '0, exp_rt = '0;
    logic [39:0] en_mask;

    always #4 clk = ~clk;

    xbar_route_cfg uut (
        .pclk(clk), .rst_n(rst_n), .ce_n(ce_n), .upd_n(upd_n),
        .par_mode(par_mode), .sdi(sdi), .sdo(sdo),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .route_sel(route_sel), .route_en(route_en)
    );

    function automatic logic [39:0] obs_word();
        logic [39:0] w;
        for (int k = 0; k < 8; k++) w[k*5 +: 5] = {route_en[k], route_sel[k*4 +: 4]};
        return w;
    endfunction

    // Pattern p: destination k gets source (5k+3p)%16, enabled unless (k+p)%3==0.
    function automatic logic [39:0] pattern(int p);
        logic [39:0] w;
        for (int k = 0; k < 8; k++) begin
            w[k*5 + 4]   = ((k + p) % 3) != 0;
            w[k*5 +: 4]  = 4'((5*k + 3*p) % 16);
        end
        return w;
    endfunction

    task automatic check(string tag, logic [39:0] act, logic [39:0] exp, logic [39:0] mask);
        nchk++;
        if ((act & mask) !== (exp & mask)) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act & mask, exp & mask);
        end
    endtask

    // One falling edge with the given pin values; model follows R1-R8.
    task automatic tick(logic r, logic c, logic u, logic p, logic d,
                        logic [2:0] a, logic [4:0] w);
        rst_n = r; ce_n = c; upd_n = u; par_mode = p; sdi = d; wr_addr = a; wr_data = w;
        if (!r) begin
            exp_sr = exp_sr & ~en_mask;
            exp_rt = exp_rt & ~en_mask;
        end else if (!c) begin
            if (!p) begin
                exp_sr = {exp_sr[38:0], d};
                if (!u) exp_rt = exp_sr;
            end else begin
                exp_sr[a*5 +: 5] = w;
                if (!u) exp_rt[a*5 +: 5] = w;
            end
        end
        @(posedge clk);
    endtask

    task automatic check_all(string tag);
        check(tag, obs_word(), exp_rt, '1);
        check(tag, {39'd0, sdo}, {39'd0, exp_sr[39]}, 40'd1);
    endtask

    // Serial load, strobe low only on the last bit.
    task automatic serial_load(logic [39:0] w, bit checks);
        for (int i = 39; i >= 0; i--) begin
            tick(1, 0, (i == 0) ? 1'b0 : 1'b1, 0, w[i], 3'd0, 5'd0);
            if (checks && i != 0) begin
                check("R3 route holds while shifting", obs_word(), exp_rt, '1);
                check("R5 sdo", {39'd0, sdo}, {39'd0, exp_sr[39]}, 40'd1);
            end
        end
        check("R1 serial word layout", obs_word(), w, '1);
    endtask

    initial begin
        for (int k = 0; k < 40; k++) en_mask[k] = (k % 5) == 4;
        @(posedge clk);
        // R8: reset disables all destinations.
        repeat (3) tick(0, 1, 1, 0, 0, 3'd0, 5'd0);
        check("R8 reset enables", obs_word(), 40'd0, en_mask);
        // First serial load: rank contents become known; R3 on enables only.
        for (int i = 39; i >= 0; i--) begin
            tick(1, 0, (i == 0) ? 1'b0 : 1'b1, 0, pattern(0)[i], 3'd0, 5'd0);
            if (i != 0) check("R3 enables held", obs_word(), 40'd0, en_mask);
        end
        check("R1 first load", obs_word(), pattern(0), '1);
        check("R5 sdo after load", {39'd0, sdo}, {39'd0, pattern(0)[39]}, 40'd1);
        for (int p = 1; p <= 4; p++) serial_load(pattern(p), 1);
        // R2: strobe held low, every intermediate word reaches the routing.
        for (int i = 39; i >= 0; i--) begin
            tick(1, 0, 0, 0, pattern(5)[i], 3'd0, 5'd0);
            check("R2 transparent follow", obs_word(), exp_sr, '1);
        end
        // R4: chip enable high, everything else toggling.
        for (int i = 0; i < 12; i++) begin
            tick(1, 1, 1'(i % 2), 1'(i % 3 == 0), 1'(i % 2 == 0), 3'(i), 5'(7*i));
            check_all("R4 idle holds");
        end
        // R6: every address and every field value.
        for (int a = 0; a < 8; a++)
            for (int d = 0; d < 32; d++) begin
                tick(1, 0, 0, 1, 0, 3'(a), 5'(d));
                check_all("R6 parallel write");
            end
        // R7: write with strobe high, then shift it out.
        tick(1, 0, 1, 1, 0, 3'd3, 5'h1A);
        check_all("R7 routing unchanged");
        tick(1, 0, 1, 1, 0, 3'd6, 5'h07);
        check_all("R7 routing unchanged");
        for (int i = 0; i < 40; i++) begin
            tick(1, 0, 1, 0, 0, 3'd0, 5'd0);
            check_all("R7 field shifted out");
        end
        // R8: reset keeps sources in both ranks.
        serial_load(pattern(2), 0);
        tick(0, 0, 0, 1, 0, 3'd1, 5'h1F);
        check_all("R8 reset wins over write");
        tick(0, 0, 0, 0, 1, 3'd0, 5'd0);
        check("R8 sources kept", obs_word(), pattern(2) & ~en_mask, '1);
        for (int i = 0; i < 40; i++) begin
            tick(1, 0, 1, 0, 0, 3'd0, 5'd0);
            check_all("R8 shift rank after reset");
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule